// File: doc/BRIEF.md
# Switch Register Access Sequencer over a Pseudo-PHY Window

This block reaches the internal registers of an Ethernet switch through an indirect window that the switch exposes as a management port at a fixed address. A single request carries an 8-bit page, an 8-bit register offset, a direction flag and 64 bits of write data. The sequencer turns it into a chain of 16-bit management commands for a separate frame master. Each command is a write or read of one window register. The chain selects the page, loads the offset, moves data through four 16-bit data registers, starts the operation and then polls until the switch reports that it is idle.

The frame master handles all bit-level framing. The sequencer only presents one command at a time with a valid/ready handshake, and then waits for the master's response pulse. A read returns the 64-bit value assembled from the four data registers. The block holds one access at a time. It signals completion with a single-cycle pulse, which is paired with an error flag when polling runs out.

Top module: `pphy_access_seq`

## Requirements
- R1: Every command carries management port address 0x1E.
- R2: The first command of every access writes window register 16 with the page in bits 15:8 and bit 0 set (value {page, 8'h01}).
- R3: A write access issues, in order: register 16 page write; register 17 = {offset, 8'h00}; registers 24, 25, 26, 27 = write data bits 15:0, 31:16, 47:32, 63:48; register 17 = {offset, 8'h01}; then status polls.
- R4: A read access issues, in order: register 16 page write; register 17 = {offset, 8'h00}; register 17 = {offset, 8'h02}; status polls; reads of registers 24, 25, 26, 27; finally register 17 = 16'h0000.
- R5: A status poll is a read of register 17. Polling repeats while the returned bits 1:0 are nonzero and moves on at the first response with bits 1:0 equal to 00.
- R6: If POLL_LIMIT polls in a row all return nonzero bits 1:0, the access ends with done and err high and rdata zero, and no further command is issued.
- R7: Read data is assembled as register 24 → rdata[15:0], 25 → [31:16], 26 → [47:32], 27 → [63:48]. A successful write reports rdata zero.
- R8: done is high for exactly one cycle per access. rdata and err are valid in that cycle, and err is low on success.
- R9: A request is taken only while req_ready is high (idle). req_valid asserted during an access has no effect on the command stream or the result.
- R10: A command's fields stay stable while cmd_valid is high and cmd_ready low. After acceptance, no new command appears until rsp_valid.
- R11: After reset, req_ready is high and cmd_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_page | input | 8 | Switch register page |
| req_offset | input | 8 | Register offset within the page |
| req_wdata | input | 64 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached, valid with done |
| rdata | output | 64 | Read result, valid with done |
| cmd_valid | output | 1 | Command presented to the frame master |
| cmd_ready | input | 1 | Frame master accepts the command |
| cmd_write | output | 1 | 1 = management write, 0 = management read |
| cmd_port | output | 5 | Management port address |
| cmd_regnum | output | 5 | Window register number |
| cmd_wdata | output | 16 | Write value (zero for reads) |
| rsp_valid | input | 1 | One-cycle pulse: the command has completed |
| rsp_rdata | input | 16 | Read value, meaningful with rsp_valid after a read |

## Verification
The assertions assume the frame master follows the protocol. It raises rsp_valid only in a cycle after a command has been accepted, gives exactly one response per command, and never responds while a command is still waiting for cmd_ready. The assertions also assume requests arrive from a source that honours req_ready. The bench's master model enforces this with a small state machine. Acceptance happens on one edge, the response comes at least one edge later, and the model never holds more than one command. Random stalls and response delays vary the handshake timing without breaking that order. Out-of-turn request strobes are injected only while the block is busy, to show that they are ignored.

// File: rtl/pphy_pkg.sv
package pphy_pkg;

  localparam int LANES      = 4;
  localparam int LANE_W     = 16;
  localparam int DATA_W     = LANES * LANE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int STEP_W     = 4;

  localparam logic [4:0] WIN_PAGE  = 5'd16;
  localparam logic [4:0] WIN_CTRL  = 5'd17;
  localparam logic [4:0] WIN_DATA0 = 5'd24;

  localparam logic [1:0] CODE_IDLE  = 2'd0;
  localparam logic [1:0] CODE_WRITE = 2'd1;
  localparam logic [1:0] CODE_READ  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_CMD,
    STEP_POLL,
    STEP_LANE
  } step_kind_e;

  typedef struct packed {
    logic                  wr;
    logic [4:0]            regnum;
    logic [LANE_W-1:0]     wdata;
    step_kind_e            kind;
    logic                  last;
    logic [LANE_IDX_W-1:0] lane;
  } step_t;

endpackage

// File: rtl/pphy_step_rom.sv
module pphy_step_rom
  import pphy_pkg::*;
(
  input  logic              is_write,
  input  logic [7:0]        page,
  input  logic [7:0]        offset,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STEP_W-1:0] step,
  output step_t             step_o
);

  logic [STEP_W-1:0] rel_wr;
  logic [STEP_W-1:0] rel_rd;

  always_comb begin
    rel_wr = step - STEP_W'(2);
    rel_rd = step - STEP_W'(4);
    step_o        = '0;
    step_o.wr     = 1'b1;
    step_o.regnum = WIN_CTRL;
    step_o.wdata  = {offset, 6'd0, CODE_IDLE};
    step_o.kind   = STEP_CMD;
    if (is_write) begin
      case (step)
        4'd0: begin
          step_o.regnum = WIN_PAGE;
          step_o.wdata  = {page, 7'd0, 1'b1};
        end
        4'd1: ;
        4'd2, 4'd3, 4'd4, 4'd5: begin
          step_o.lane   = rel_wr[LANE_IDX_W-1:0];
          step_o.regnum = WIN_DATA0 + 5'(rel_wr[LANE_IDX_W-1:0]);
          step_o.wdata  = wdata[int'(rel_wr[LANE_IDX_W-1:0])*LANE_W +: LANE_W];
        end
        4'd6: step_o.wdata = {offset, 6'd0, CODE_WRITE};
        default: begin
          step_o.wr    = 1'b0;
          step_o.wdata = '0;
          step_o.kind  = STEP_POLL;
          step_o.last  = 1'b1;
        end
      endcase
    end else begin
      case (step)
        4'd0: begin
          step_o.regnum = WIN_PAGE;
          step_o.wdata  = {page, 7'd0, 1'b1};
        end
        4'd1: ;
        4'd2: step_o.wdata = {offset, 6'd0, CODE_READ};
        4'd3: begin
          step_o.wr    = 1'b0;
          step_o.wdata = '0;
          step_o.kind  = STEP_POLL;
        end
        4'd4, 4'd5, 4'd6, 4'd7: begin
          step_o.wr     = 1'b0;
          step_o.wdata  = '0;
          step_o.kind   = STEP_LANE;
          step_o.lane   = rel_rd[LANE_IDX_W-1:0];
          step_o.regnum = WIN_DATA0 + 5'(rel_rd[LANE_IDX_W-1:0]);
        end
        default: begin
          step_o.wdata = '0;
          step_o.last  = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pphy_poll_ctr.sv
module pphy_poll_ctr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (bump && !at_limit) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign at_limit = (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pphy_lane_gather.sv
module pphy_lane_gather
  import pphy_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  capture,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic [LANE_W-1:0]     din,
  output logic [DATA_W-1:0]     dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_q <= '0;
      end else if (capture && lane == LANE_IDX_W'(g)) begin
        lane_q <= din;
      end
    end
    assign dout[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/pphy_access_seq.sv
module pphy_access_seq
  import pphy_pkg::*;
#(
  parameter int         POLL_LIMIT = 16,
  parameter logic [4:0] PORT_ADDR  = 5'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_page,
  input  logic [7:0]        req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [4:0]        cmd_port,
  output logic [4:0]        cmd_regnum,
  output logic [LANE_W-1:0] cmd_wdata,
  input  logic              rsp_valid,
  input  logic [LANE_W-1:0] rsp_rdata
);

  seq_state_e        state_q;
  logic              op_write_q;
  logic [7:0]        page_q;
  logic [7:0]        offset_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STEP_W-1:0] step_q;
  step_t             cur;

  logic accept, rsp_take, poll_ok, poll_bump, poll_at_limit;
  logic lane_cap, finish_ok, finish_err, advance, retry;
  logic [DATA_W-1:0] gathered;

  pphy_step_rom u_rom (
    .is_write (op_write_q),
    .page     (page_q),
    .offset   (offset_q),
    .wdata    (wdata_q),
    .step     (step_q),
    .step_o   (cur)
  );

  always_comb begin
    accept     = req_valid && (state_q == ST_IDLE);
    rsp_take   = (state_q == ST_WAIT) && rsp_valid;
    poll_ok    = (rsp_rdata[1:0] == CODE_IDLE);
    poll_bump  = rsp_take && (cur.kind == STEP_POLL) && !poll_ok;
    lane_cap   = rsp_take && (cur.kind == STEP_LANE);
    finish_ok  = rsp_take && cur.last && ((cur.kind != STEP_POLL) || poll_ok);
    finish_err = poll_bump && poll_at_limit;
    advance    = rsp_take && !cur.last && ((cur.kind != STEP_POLL) || poll_ok);
    retry      = poll_bump && !poll_at_limit;
  end

  pphy_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .bump     (poll_bump),
    .at_limit (poll_at_limit)
  );

  pphy_lane_gather u_gather (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .capture (lane_cap),
    .lane    (cur.lane),
    .din     (rsp_rdata),
    .dout    (gathered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      page_q     <= '0;
      offset_q   <= '0;
      wdata_q    <= '0;
      step_q     <= '0;
      cmd_valid  <= 1'b0;
      cmd_write  <= 1'b0;
      cmd_regnum <= '0;
      cmd_wdata  <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_write_q <= req_write;
            page_q     <= req_page;
            offset_q   <= req_offset;
            wdata_q    <= req_wdata;
            step_q     <= '0;
            state_q    <= ST_PREP;
          end
        end
        ST_PREP: begin
          cmd_write  <= cur.wr;
          cmd_regnum <= cur.regnum;
          cmd_wdata  <= cur.wr ? cur.wdata : '0;
          cmd_valid  <= 1'b1;
          state_q    <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (finish_ok || finish_err) begin
            done    <= 1'b1;
            err     <= finish_err;
            rdata   <= finish_err ? '0 : gathered;
            state_q <= ST_IDLE;
          end else if (advance) begin
            step_q  <= step_q + STEP_W'(1);
            state_q <= ST_PREP;
          end else if (retry) begin
            state_q <= ST_PREP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_port  = PORT_ADDR;

endmodule

// File: rtl/pphy_access_checker.sv
module pphy_access_checker
  import pphy_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [4:0]        cmd_regnum,
  input logic [LANE_W-1:0] cmd_wdata,
  input logic              rsp_valid
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_write) && $stable(cmd_regnum) && $stable(cmd_wdata)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rsp_valid)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R6

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    done && err |-> rdata == '0); // R6

endmodule

bind pphy_access_seq pphy_access_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .done       (done),
  .err        (err),
  .rdata      (rdata),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_write  (cmd_write),
  .cmd_regnum (cmd_regnum),
  .cmd_wdata  (cmd_wdata),
  .rsp_valid  (rsp_valid)
);

// File: tb/pphy_access_seq_bench.sv
module pphy_access_seq_bench;

  localparam int LIMIT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_page = '0;
  logic [7:0]  req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic        done, err;
  logic [63:0] rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic        cmd_write;
  logic [4:0]  cmd_port, cmd_regnum;
  logic [15:0] cmd_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  always #10 clk = ~clk;

  pphy_access_seq #(.POLL_LIMIT(LIMIT)) u_pphy_access_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_offset(req_offset),
    .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_port(cmd_port), .cmd_regnum(cmd_regnum), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected command list
  bit          exp_wr  [64];
  logic [4:0]  exp_reg [64];
  logic [15:0] exp_dat [64];
  int          exp_n;

  // switch model state
  logic [63:0] mem [int];
  logic [7:0]  sw_page, sw_off;
  logic [1:0]  sw_code;
  logic [15:0] sw_data [4];
  int          busy_left = 0;
  int          cur_busy  = 0;
  int          n_cmd = 0;
  int          trace_err = 0;
  int          port_err = 0;
  int          stab_err = 0;

  function automatic logic [63:0] seed_val(input int key);
    logic [15:0] k;
    k = key[15:0];
    return {k ^ 16'hA5A5, k * 16'd7, ~k, k + 16'h1357};
  endfunction

  function automatic logic [63:0] mem_get(input int key);
    if (mem.exists(key)) return mem[key];
    return seed_val(key);
  endfunction

  function automatic void add_exp(input bit w, input logic [4:0] r, input logic [15:0] d);
    exp_wr[exp_n]  = w;
    exp_reg[exp_n] = r;
    exp_dat[exp_n] = d;
    exp_n++;
  endfunction

  function automatic void build_exp(input bit w, input logic [7:0] pg, input logic [7:0] off,
                                    input logic [63:0] d, input int busy);
    int np;
    exp_n = 0;
    np = (busy < LIMIT) ? busy + 1 : LIMIT;
    add_exp(1'b1, 5'd16, {pg, 8'h01});
    add_exp(1'b1, 5'd17, {off, 8'h00});
    if (w) begin
      for (int i = 0; i < 4; i++) add_exp(1'b1, 5'(24 + i), d[16*i +: 16]);
      add_exp(1'b1, 5'd17, {off, 8'h01});
      for (int i = 0; i < np; i++) add_exp(1'b0, 5'd17, 16'h0);
    end else begin
      add_exp(1'b1, 5'd17, {off, 8'h02});
      for (int i = 0; i < np; i++) add_exp(1'b0, 5'd17, 16'h0);
      if (busy < LIMIT) begin
        for (int i = 0; i < 4; i++) add_exp(1'b0, 5'(24 + i), 16'h0);
        add_exp(1'b1, 5'd17, 16'h0000);
      end
    end
  endfunction

  // frame master and switch model
  int          ms = 0;
  int          delay = 0;
  logic        s_wr;
  logic [4:0]  s_reg;
  logic [15:0] s_dat;
  logic [15:0] resp;

  task automatic process_cmd();
    int key;
    if (n_cmd < exp_n) begin
      if (s_wr != exp_wr[n_cmd] || s_reg != exp_reg[n_cmd] || (s_wr && s_dat != exp_dat[n_cmd]))
        trace_err++;
    end else begin
      trace_err++;
    end
    n_cmd++;
    if (cmd_port != 5'h1E) port_err++;
    resp = 16'h0;
    if (s_wr) begin
      if (s_reg == 5'd16) sw_page = s_dat[15:8];
      else if (s_reg == 5'd17) begin
        sw_off  = s_dat[15:8];
        sw_code = s_dat[1:0];
        key = {16'h0, sw_page, sw_off};
        if (sw_code == 2'd1) begin
          mem[key] = {sw_data[3], sw_data[2], sw_data[1], sw_data[0]};
          busy_left = cur_busy;
        end else if (sw_code == 2'd2) begin
          for (int i = 0; i < 4; i++) sw_data[i] = mem_get(key) >> (16 * i);
          busy_left = cur_busy;
        end
      end else if (s_reg >= 5'd24 && s_reg <= 5'd27) sw_data[s_reg - 5'd24] = s_dat;
    end else begin
      if (s_reg == 5'd17) begin
        resp = {sw_off, 6'd0, (busy_left > 0) ? sw_code : 2'b00};
        if (busy_left > 0) busy_left--;
      end else if (s_reg >= 5'd24 && s_reg <= 5'd27) resp = sw_data[s_reg - 5'd24];
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b0;
      rsp_valid <= 1'b0;
      ms = 0;
    end else begin
      case (ms)
        0: begin
          rsp_valid <= 1'b0;
          if (cmd_valid) begin
            s_wr = cmd_write; s_reg = cmd_regnum; s_dat = cmd_wdata;
            if ($urandom % 3 != 0) begin cmd_ready <= 1'b1; ms = 1; end
            else ms = 3;
          end
        end
        3: begin
          if (!cmd_valid || cmd_write != s_wr || cmd_regnum != s_reg || cmd_wdata != s_dat) stab_err++;
          cmd_ready <= 1'b1;
          ms = 1;
        end
        1: begin
          cmd_ready <= 1'b0;
          process_cmd();
          delay = $urandom % 3;
          ms = 2;
        end
        default: begin
          if (delay == 0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= resp;
            ms = 0;
          end else delay--;
        end
      endcase
    end
  end

  task automatic access(input bit w, input logic [7:0] pg, input logic [7:0] off,
                        input logic [63:0] d, input int busy, input bit noise);
    bit          exp_err;
    logic [63:0] exp_rd;
    int          cyc;
    string       tag;
    build_exp(w, pg, off, d, busy);
    exp_err = (busy >= LIMIT);
    exp_rd  = (w || exp_err) ? 64'h0 : mem_get({16'h0, pg, off});
    tag = exp_err ? "R6" : (w ? "R3" : "R4");
    cur_busy = busy; n_cmd = 0; trace_err = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_page = pg; req_offset = off; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", 64'(req_ready), 64'h0);
    if (noise) begin
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_write = ~w; req_page = ~pg; req_offset = ~off; req_wdata = ~d;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done, "R8 done seen", 64'(done), 64'h1);
    chk(err == exp_err, exp_err ? "R6 err flag" : "R8 err low", 64'(err), 64'(exp_err));
    chk(rdata == exp_rd, w ? "R7 write rdata zero" : "R7 read data", rdata, exp_rd);
    @(negedge clk);
    chk(!done, "R8 done one cycle", 64'(done), 64'h0);
    repeat (6) @(negedge clk);
    chk(n_cmd == exp_n, {tag, " command count"}, 64'(n_cmd), 64'(exp_n));
    chk(trace_err == 0, {tag, " command order, R2 page, R5 polls"}, 64'(trace_err), 64'h0);
    if (noise) chk(trace_err == 0, "R9 ignored request", 64'(trace_err), 64'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0B1E));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R11 reset req_ready", 64'(req_ready), 64'h1);
    chk(!cmd_valid, "R11 reset cmd_valid", 64'(cmd_valid), 64'h0);
    chk(!done, "R11 reset done", 64'(done), 64'h0);

    access(1'b1, 8'd34, 8'd10, 64'h0123_4567_89AB_55AA, 0, 1'b0);
    access(1'b0, 8'd34, 8'd10, 64'h0, 0, 1'b0);
    access(1'b0, 8'd1, 8'd70, 64'h0, 2, 1'b0);
    access(1'b1, 8'hFF, 8'hFF, 64'hFFFF_0000_FFFF_0000, LIMIT - 1, 1'b0);
    access(1'b0, 8'hFF, 8'hFF, 64'h0, LIMIT - 1, 1'b0);
    access(1'b0, 8'd3, 8'd4, 64'h0, LIMIT, 1'b0);
    access(1'b1, 8'd5, 8'd6, 64'hDEAD_BEEF_CAFE_F00D, LIMIT + 2, 1'b0);
    access(1'b0, 8'd5, 8'd6, 64'h0, 1, 1'b1);
    access(1'b1, 8'd0, 8'd0, 64'h1111_2222_3333_4444, 3, 1'b1);

    for (int n = 0; n < 24; n++) begin
      access(1'($urandom % 2), 8'($urandom % 4), 8'($urandom % 4),
             {$urandom, $urandom}, int'($urandom % (LIMIT + 2)), ($urandom % 4) == 0);
    end

    chk(port_err == 0, "R1 port address", 64'(port_err), 64'h0);
    chk(stab_err == 0, "R10 held command", 64'(stab_err), 64'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule